// File: doc/BRIEF.md
# Dual-Codeword Symbol Splitter and Lane Dealer

This block sits on the transmit path on both sides of a pair of Reed-Solomon encoders. A scrambled stream of 10-bit symbols enters on one valid/ready port. The block passes the symbols straight through to two encoder ports in strict alternation. The first symbol of a codeword pair goes to encoder A, the next to encoder B, and so on, until both codewords hold their 514 message symbols. Each encoder then returns 30 parity symbols on its own valid/ready port. The block stores message and parity symbols together, so each codeword holds 544 symbols.

On the output side, the stored pair is dealt to the lanes one beat at a time. A beat carries one symbol per active lane. Within a beat, adjacent lanes take matching symbols from A and B. Which codeword goes to the even lanes swaps on every beat. The result is a checkerboard in which neighbouring symbols of any lane come from alternate codewords. A static mode pin selects 8 or 16 lanes and is captured only while reset is asserted. The output port does not wait for the whole pair. A beat is offered as soon as both codewords hold every symbol that beat needs, so message beats leave while parity is still outstanding.

Back-pressure rules:
- `in_ready` is the ready of whichever encoder is the current target. It is forced low once the pair has all 1028 message symbols and stays low until the last beat of the pair has left.
- Each parity port is ready only inside its codeword's parity window.
- Once `lane_valid` is high, it and `lane_syms` hold until `lane_ready` is seen.

Top module: `fec_lane_distributor`

## Requirements
- R1: Input symbol n of a pair (n counted from 0) is forwarded to encoder A when n is even and to encoder B when n is odd. It becomes symbol n/2 (integer division) of that codeword. `enc_a_sym`/`enc_b_sym` equal `in_sym`, and only the targeted encoder's valid is raised.
- R2: `in_ready` equals the ready of the targeted encoder while fewer than 1028 message symbols of the current pair have been taken. It is low after that until the pair has been fully dealt.
- R3: For each codeword, the parity port is ready exactly while that codeword holds at least 514 and fewer than 544 symbols. Parity symbol k (0 to 29) becomes codeword symbol 514+k.
- R4: With H = lanes/2, beat t of a pair carries, on lane l, symbol t*H + l/2 of codeword A if (l mod 2) XOR (t mod 2) is 0, otherwise of codeword B. Lane l occupies bits [10*l+9 : 10*l] of `lane_syms`.
- R5: `lane_valid` is high exactly when the current beat is not past the end of the pair and both codewords already hold symbols 0 to (t+1)*H-1. Message-only beats are therefore offered before parity arrives, and the port stalls on beats that need missing parity.
- R6: While `lane_valid` is high and `lane_ready` is low, `lane_valid` stays high and `lane_syms` stays unchanged on the next cycle.
- R7: A pair takes 136 beats in 8-lane mode and 68 in 16-lane mode. After the last beat, storage empties and the next pair's first symbol is accepted again for encoder A.
- R8: `wide_mode` (1 = 16 lanes, 0 = 8 lanes) is captured only while `rst` is high. Changing it afterwards has no effect on the lane output.
- R9: During and right after reset, `lane_valid` and both parity readies are low. `in_ready` is high when encoder A is ready.
- R10: In 8-lane mode, lanes 8 to 15 of `lane_syms` are zero on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | Lane mode: 1 = 16 lanes, 0 = 8 lanes; captured during reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Input symbol accepted |
| in_sym | input | 10 | Scrambled input symbol |
| enc_a_valid | output | 1 | Message symbol valid toward encoder A |
| enc_a_ready | input | 1 | Encoder A can take a symbol |
| enc_a_sym | output | 10 | Message symbol toward encoder A |
| enc_b_valid | output | 1 | Message symbol valid toward encoder B |
| enc_b_ready | input | 1 | Encoder B can take a symbol |
| enc_b_sym | output | 10 | Message symbol toward encoder B |
| par_a_valid | input | 1 | Parity symbol valid from encoder A |
| par_a_ready | output | 1 | Parity from encoder A accepted |
| par_a_sym | input | 10 | Parity symbol from encoder A |
| par_b_valid | input | 1 | Parity symbol valid from encoder B |
| par_b_ready | output | 1 | Parity from encoder B accepted |
| par_b_sym | input | 10 | Parity symbol from encoder B |
| lane_valid | output | 1 | Lane beat valid |
| lane_ready | input | 1 | Lane beat consumed |
| lane_syms | output | 160 | One 10-bit symbol per lane, lane l at bits 10*l+9..10*l |

## Verification
The bench sweeps full codeword pairs in both lane modes while applying patterned back-pressure on every port. It holds parity back long enough to expose the window in which message beats must flow and parity beats must stall; a design that waited for a full pair, or that raced ahead, would show a `lane_valid` mismatch on that cycle. Every beat is compared lane by lane against the checkerboard formula. A dealer that fixed codeword A on the even lanes, or that stepped by the wrong half-width, fails on the second beat. Flipping the mode pin mid-run checks that a design which follows the live pin, rather than the value captured at reset, is caught by non-zero upper lanes or a wrong step.

// File: rtl/fec_dist_pkg.sv
package fec_dist_pkg;

  // Codeword selector used by the splitter and the lane dealer
  typedef enum logic {
    CW_A = 1'b0,
    CW_B = 1'b1
  } cw_e;

  // Checkerboard rule: the codeword feeding a lane flips every beat
  function automatic cw_e lane_source(input logic beat_odd, input logic lane_odd);
    return (beat_odd ^ lane_odd) ? CW_B : CW_A;
  endfunction

endpackage

// File: rtl/fec_dist_splitter.sv
module fec_dist_splitter
  import fec_dist_pkg::*;
#(
  parameter int SYM_W    = 10,
  parameter int MSG_SYMS = 514
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_sym,
  output logic             enc_a_valid,
  input  logic             enc_a_ready,
  output logic [SYM_W-1:0] enc_a_sym,
  output logic             enc_b_valid,
  input  logic             enc_b_ready,
  output logic [SYM_W-1:0] enc_b_sym,
  output logic             wr_a,
  output logic             wr_b,
  output logic [SYM_W-1:0] wr_sym
);
  localparam int PAIR_MSG = 2 * MSG_SYMS;
  localparam int CNT_W    = $clog2(PAIR_MSG + 1);

  cw_e              target;
  logic [CNT_W-1:0] taken;
  logic             open;
  logic             fire;

  assign open        = (taken != CNT_W'(PAIR_MSG));
  assign in_ready    = open && ((target == CW_A) ? enc_a_ready : enc_b_ready);
  assign enc_a_valid = in_valid && open && (target == CW_A);
  assign enc_b_valid = in_valid && open && (target == CW_B);
  assign enc_a_sym   = in_sym;
  assign enc_b_sym   = in_sym;
  assign fire        = in_valid && in_ready;
  assign wr_a        = fire && (target == CW_A);
  assign wr_b        = fire && (target == CW_B);
  assign wr_sym      = in_sym;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      taken  <= '0;
      target <= CW_A;
    end else if (fire) begin
      taken  <= taken + 1'b1;
      target <= (target == CW_A) ? CW_B : CW_A;
    end
  end

  // R2: nothing reaches an encoder once the pair's message quota is used
  p_quota_r2: assert property (@(posedge clk) disable iff (rst)
    (taken == CNT_W'(PAIR_MSG)) |-> (!enc_a_valid && !enc_b_valid));

endmodule

// File: rtl/fec_dist_bank.sv
module fec_dist_bank #(
  parameter int SYM_W    = 10,
  parameter int MSG_SYMS = 514,
  parameter int PAR_SYMS = 30,
  parameter int RD_N     = 8,
  localparam int CW_SYMS = MSG_SYMS + PAR_SYMS,
  localparam int CNT_W   = $clog2(CW_SYMS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  msg_we,
  input  logic [SYM_W-1:0]      msg_sym,
  input  logic                  par_valid,
  output logic                  par_ready,
  input  logic [SYM_W-1:0]      par_sym,
  output logic [CNT_W-1:0]      fill,
  input  logic [CNT_W-1:0]      rd_base,
  output logic [RD_N*SYM_W-1:0] rd_syms
);
  logic [SYM_W-1:0] mem [CW_SYMS];
  logic             we;
  logic [SYM_W-1:0] wsym;

  assign par_ready = (fill >= CNT_W'(MSG_SYMS)) && (fill < CNT_W'(CW_SYMS));
  assign we        = msg_we || (par_valid && par_ready);
  assign wsym      = msg_we ? msg_sym : par_sym;

  always_ff @(posedge clk) begin
    if (rst || clear) fill <= '0;
    else if (we)      fill <= fill + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we && (fill < CNT_W'(CW_SYMS))) mem[fill] <= wsym;
  end

  for (genvar k = 0; k < RD_N; k++) begin : g_rd
    logic [CNT_W:0] idx;
    assign idx = {1'b0, rd_base} + (CNT_W+1)'(k);
    assign rd_syms[k*SYM_W +: SYM_W] =
      (idx < (CNT_W+1)'(CW_SYMS)) ? mem[idx[CNT_W-1:0]] : '0;
  end

  // R3: storage never overflows the codeword
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(CW_SYMS));

  // R3: parity is never taken in a cycle that also writes a message symbol
  p_par_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (par_valid && par_ready) |-> !msg_we);

endmodule

// File: rtl/fec_dist_dealer.sv
module fec_dist_dealer
  import fec_dist_pkg::*;
#(
  parameter int SYM_W     = 10,
  parameter int CW_SYMS   = 544,
  parameter int LANES_MAX = 16,
  parameter int LANES_MIN = 8,
  localparam int HALF_MAX = LANES_MAX / 2,
  localparam int HALF_MIN = LANES_MIN / 2,
  localparam int CNT_W    = $clog2(CW_SYMS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wide,
  input  logic [CNT_W-1:0]           fill_a,
  input  logic [CNT_W-1:0]           fill_b,
  input  logic [HALF_MAX*SYM_W-1:0]  rd_a,
  input  logic [HALF_MAX*SYM_W-1:0]  rd_b,
  output logic [CNT_W-1:0]           rd_base,
  input  logic                       lane_ready,
  output logic                       lane_valid,
  output logic [LANES_MAX*SYM_W-1:0] lane_syms,
  output logic                       pair_done
);
  logic [CNT_W:0] step;
  logic [CNT_W:0] need;
  logic           beat_odd;
  logic           fire;

  assign step       = wide ? (CNT_W+1)'(HALF_MAX) : (CNT_W+1)'(HALF_MIN);
  assign need       = {1'b0, rd_base} + step;
  assign lane_valid = ({1'b0, fill_a} >= need) && ({1'b0, fill_b} >= need);
  assign fire       = lane_valid && lane_ready;
  assign pair_done  = fire && (need == (CNT_W+1)'(CW_SYMS));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_base  <= '0;
      beat_odd <= 1'b0;
    end else if (fire) begin
      if (pair_done) begin
        rd_base  <= '0;
        beat_odd <= 1'b0;
      end else begin
        rd_base  <= need[CNT_W-1:0];
        beat_odd <= ~beat_odd;
      end
    end
  end

  for (genvar l = 0; l < LANES_MAX; l++) begin : g_lane
    localparam int J = l / 2;
    logic [SYM_W-1:0] pick;
    assign pick = (lane_source(beat_odd, 1'(l % 2)) == CW_B) ?
                  rd_b[J*SYM_W +: SYM_W] : rd_a[J*SYM_W +: SYM_W];
    if (l < LANES_MIN) begin : g_always
      assign lane_syms[l*SYM_W +: SYM_W] = pick;
    end else begin : g_wide_only
      assign lane_syms[l*SYM_W +: SYM_W] = wide ? pick : '0;
    end
  end

  // R6: an offered beat is held steady until taken
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (lane_valid && !lane_ready) |=> (lane_valid && $stable(lane_syms)));

  // R4: each taken beat advances the read base by one half-width or wraps to zero
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && !pair_done) |=> (rd_base != '0) && (beat_odd != $past(beat_odd)));

endmodule

// File: rtl/fec_lane_distributor.sv
module fec_lane_distributor
  import fec_dist_pkg::*;
#(
  parameter int SYM_W     = 10,
  parameter int MSG_SYMS  = 514,
  parameter int PAR_SYMS  = 30,
  parameter int LANES_MAX = 16,
  parameter int LANES_MIN = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wide_mode,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [SYM_W-1:0]           in_sym,
  output logic                       enc_a_valid,
  input  logic                       enc_a_ready,
  output logic [SYM_W-1:0]           enc_a_sym,
  output logic                       enc_b_valid,
  input  logic                       enc_b_ready,
  output logic [SYM_W-1:0]           enc_b_sym,
  input  logic                       par_a_valid,
  output logic                       par_a_ready,
  input  logic [SYM_W-1:0]           par_a_sym,
  input  logic                       par_b_valid,
  output logic                       par_b_ready,
  input  logic [SYM_W-1:0]           par_b_sym,
  output logic                       lane_valid,
  input  logic                       lane_ready,
  output logic [LANES_MAX*SYM_W-1:0] lane_syms
);
  localparam int CW_SYMS  = MSG_SYMS + PAR_SYMS;
  localparam int CNT_W    = $clog2(CW_SYMS + 1);
  localparam int HALF_MAX = LANES_MAX / 2;

  logic                                 wide_q;
  logic                                 pair_done;
  logic                                 wr_a, wr_b;
  logic [SYM_W-1:0]                     wr_sym;
  logic [CNT_W-1:0]                     rd_base;
  logic [1:0]                           bank_we;
  logic [1:0]                           bank_pv;
  logic [1:0]                           bank_pr;
  logic [1:0][SYM_W-1:0]                bank_ps;
  logic [1:0][CNT_W-1:0]                bank_fill;
  logic [1:0][HALF_MAX*SYM_W-1:0]       bank_rd;

  // Mode is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) wide_q <= wide_mode;
  end

  fec_dist_splitter #(.SYM_W(SYM_W), .MSG_SYMS(MSG_SYMS)) u_split (
    .clk(clk), .rst(rst), .clear(pair_done),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .enc_a_valid(enc_a_valid), .enc_a_ready(enc_a_ready), .enc_a_sym(enc_a_sym),
    .enc_b_valid(enc_b_valid), .enc_b_ready(enc_b_ready), .enc_b_sym(enc_b_sym),
    .wr_a(wr_a), .wr_b(wr_b), .wr_sym(wr_sym)
  );

  assign bank_we     = {wr_b, wr_a};
  assign bank_pv     = {par_b_valid, par_a_valid};
  assign bank_ps     = {par_b_sym, par_a_sym};
  assign par_a_ready = bank_pr[0];
  assign par_b_ready = bank_pr[1];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    fec_dist_bank #(
      .SYM_W(SYM_W), .MSG_SYMS(MSG_SYMS), .PAR_SYMS(PAR_SYMS), .RD_N(HALF_MAX)
    ) u_bank (
      .clk(clk), .rst(rst), .clear(pair_done),
      .msg_we(bank_we[g]), .msg_sym(wr_sym),
      .par_valid(bank_pv[g]), .par_ready(bank_pr[g]), .par_sym(bank_ps[g]),
      .fill(bank_fill[g]), .rd_base(rd_base), .rd_syms(bank_rd[g])
    );
  end

  fec_dist_dealer #(
    .SYM_W(SYM_W), .CW_SYMS(CW_SYMS), .LANES_MAX(LANES_MAX), .LANES_MIN(LANES_MIN)
  ) u_deal (
    .clk(clk), .rst(rst), .wide(wide_q),
    .fill_a(bank_fill[0]), .fill_b(bank_fill[1]),
    .rd_a(bank_rd[0]), .rd_b(bank_rd[1]), .rd_base(rd_base),
    .lane_ready(lane_ready), .lane_valid(lane_valid), .lane_syms(lane_syms),
    .pair_done(pair_done)
  );

  // R1: while A still takes message symbols, A leads B by zero or one
  p_alt_r1: assert property (@(posedge clk) disable iff (rst)
    (bank_fill[0] < CNT_W'(MSG_SYMS)) |->
      ((bank_fill[0] == bank_fill[1]) || (bank_fill[0] == bank_fill[1] + 1'b1)));

  // R2: a full pair blocks the input
  p_full_block_r2: assert property (@(posedge clk) disable iff (rst)
    ((bank_fill[0] == CNT_W'(CW_SYMS)) && (bank_fill[1] == CNT_W'(CW_SYMS))) |-> !in_ready);

  // R3: encoder A is never fed message while its parity window is open
  p_par_window_r3: assert property (@(posedge clk) disable iff (rst)
    par_a_ready |-> !enc_a_valid);

  // R7: the last beat empties both codeword stores
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    pair_done |=> ((bank_fill[0] == '0) && (bank_fill[1] == '0)));

  // R8: captured mode does not move outside reset
  p_mode_static_r8: assert property (@(posedge clk) disable iff (rst)
    $stable(wide_q));

  // R9: nothing is offered on the lanes just after reset
  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!lane_valid && !par_a_ready && !par_b_ready));

endmodule

// File: tb/fec_lane_distributor_test.sv
module fec_lane_distributor_test;
  localparam int SW    = 10;
  localparam int MSG   = 514;
  localparam int CW    = 544;
  localparam int LMAX  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide_mode = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [SW-1:0] in_sym = '0;
  logic enc_a_valid, enc_b_valid;
  logic enc_a_ready = 1'b1, enc_b_ready = 1'b1;
  logic [SW-1:0] enc_a_sym, enc_b_sym;
  logic par_a_valid = 1'b0, par_b_valid = 1'b0;
  logic par_a_ready, par_b_ready;
  logic [SW-1:0] par_a_sym = '0, par_b_sym = '0;
  logic lane_valid;
  logic lane_ready = 1'b0;
  logic [LMAX*SW-1:0] lane_syms;

  int checks = 0;
  int errors = 0;

  fec_lane_distributor uut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .enc_a_valid(enc_a_valid), .enc_a_ready(enc_a_ready), .enc_a_sym(enc_a_sym),
    .enc_b_valid(enc_b_valid), .enc_b_ready(enc_b_ready), .enc_b_sym(enc_b_sym),
    .par_a_valid(par_a_valid), .par_a_ready(par_a_ready), .par_a_sym(par_a_sym),
    .par_b_valid(par_b_valid), .par_b_ready(par_b_ready), .par_b_sym(par_b_sym),
    .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_syms(lane_syms)
  );

  // 50 MHz: 20 time-unit period
  initial forever #10 clk = ~clk;

  function automatic int msg_val(input int p, input int n);
    return (n * 7 + p * 131 + 3) & 1023;
  endfunction

  function automatic int par_val(input int p, input int cw, input int k);
    return (p * 53 + cw * 211 + k * 29 + 700) & 1023;
  endfunction

  function automatic int exp_sym(input int p, input int cw, input int i);
    if (i < MSG) return msg_val(p, 2 * i + cw);
    return par_val(p, cw, i - MSG);
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic run_phase(input logic wide_cfg);
    int L, H, beats_per, pair, msg_acc, av_a, av_b, beats, dly_a, dly_b, cyc;
    logic flipped, hold;
    logic [LMAX*SW-1:0] held;
    L = wide_cfg ? 16 : 8;
    H = L / 2;
    beats_per = 1088 / L;
    pair = 0; msg_acc = 0; av_a = 0; av_b = 0; beats = 0; dly_a = 0; dly_b = 0;
    cyc = 0; flipped = 1'b0; hold = 1'b0; held = '0;

    // Reset with chosen mode (R9)
    @(negedge clk);
    rst = 1'b1; wide_mode = wide_cfg; in_valid = 1'b0; par_a_valid = 1'b0;
    par_b_valid = 1'b0; enc_a_ready = 1'b1; enc_b_ready = 1'b1; lane_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "lane_valid in reset", int'(lane_valid), 0);
    chk("R9", "par_a_ready in reset", int'(par_a_ready), 0);
    chk("R9", "par_b_ready in reset", int'(par_b_ready), 0);
    rst = 1'b0;
    #1;
    chk("R9", "in_ready after reset", int'(in_ready), 1);

    while (pair < 2) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog: phase stuck, got %0d pairs expected 2", pair);
        break;
      end
      if (cyc == 700) begin
        wide_mode = ~wide_mode;
        flipped = 1'b1;
      end
      in_valid    = (msg_acc < 2 * MSG) && ((cyc % 11) != 4);
      in_sym      = SW'(msg_val(pair, msg_acc));
      enc_a_ready = (cyc % 7) != 3;
      enc_b_ready = (cyc % 5) != 1;
      par_a_valid = (av_a >= MSG) && (av_a < CW) && (dly_a >= 25) && ((cyc % 3) != 0);
      par_a_sym   = SW'(par_val(pair, 0, (av_a >= MSG) ? av_a - MSG : 0));
      par_b_valid = (av_b >= MSG) && (av_b < CW) && (dly_b >= 40) && ((cyc % 3) != 1);
      par_b_sym   = SW'(par_val(pair, 1, (av_b >= MSG) ? av_b - MSG : 0));
      lane_ready  = (cyc % 9) != 2;
      #1;

      if (hold) begin
        chk("R6", "valid held", int'(lane_valid), 1);
        chk("R6", "data held", int'(lane_syms == held), 1);
      end
      chk("R2", "in_ready", int'(in_ready),
          int'((msg_acc < 2 * MSG) && ((msg_acc % 2 == 0) ? enc_a_ready : enc_b_ready)));
      chk("R3", "par_a_ready", int'(par_a_ready), int'((av_a >= MSG) && (av_a < CW)));
      chk("R3", "par_b_ready", int'(par_b_ready), int'((av_b >= MSG) && (av_b < CW)));
      chk("R5", "lane_valid", int'(lane_valid),
          int'((beats < beats_per) && (av_a >= (beats + 1) * H) && (av_b >= (beats + 1) * H)));

      if (in_valid && in_ready) begin
        if (msg_acc % 2 == 0) begin
          chk("R1", "route to A", int'({enc_a_valid, enc_b_valid}), 2);
          chk("R1", "enc_a_sym", int'(enc_a_sym), exp_sym(pair, 0, msg_acc / 2));
          av_a++;
        end else begin
          chk("R1", "route to B", int'({enc_a_valid, enc_b_valid}), 1);
          chk("R1", "enc_b_sym", int'(enc_b_sym), exp_sym(pair, 1, msg_acc / 2));
          av_b++;
        end
        msg_acc++;
      end
      if (par_a_valid && par_a_ready) av_a++;
      if (par_b_valid && par_b_ready) av_b++;
      if (av_a >= MSG) dly_a++;
      if (av_b >= MSG) dly_b++;

      hold = lane_valid && !lane_ready;
      held = lane_syms;

      if (lane_valid && lane_ready) begin
        for (int l = 0; l < LMAX; l++) begin
          int got, exp;
          got = int'(lane_syms[l*SW +: SW]);
          if (l < L) begin
            exp = exp_sym(pair, ((l % 2) ^ (beats % 2)), beats * H + l / 2);
            if (got != exp) chk(flipped ? "R8" : "R4", "lane symbol", got, exp);
          end else begin
            if (got != 0) chk("R10", "upper lane zero", got, 0);
          end
        end
        chk(flipped ? "R8" : "R4", "beat matched", 1, 1);
        beats++;
        if (beats == beats_per) begin
          chk("R7", "storage full at last beat", int'((av_a == CW) && (av_b == CW)), 1);
          pair++; msg_acc = 0; av_a = 0; av_b = 0; beats = 0; dly_a = 0; dly_b = 0;
        end
      end
    end
    if (!wide_cfg) chk("R10", "narrow phase completed pairs", pair, 2);
    else           chk("R7", "wide phase completed pairs", pair, 2);
  endtask

  initial begin
    run_phase(1'b0);
    run_phase(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule